// File: doc/BRIEF.md
# Descriptor Ring Ownership Manager

This block walks a receive ring and a transmit ring of descriptors that a controller shares with software in memory. After a start pulse it reads a twelve-word initialization block from a 24-bit byte address that arrives as a low half and a high byte. The block captures each ring's base address and size. It loads each ring's current-descriptor pointer with the base and works out the pointer to the following entry. Each descriptor occupies four 16-bit words, so one entry is 8 bytes. Ring sizes are powers of two from 1 to 128 entries, and the last entry wraps back to the base.

At run time each ring walker reads the status word of its current descriptor, which is word 1 at byte offset 2. Bit 15 of that word is the ownership flag, and a value of 1 means the controller holds the entry. An owned entry is offered to the user through a level signal. When the user signals completion, the walker writes the status word back once with bit 15 cleared, moves to the next entry and fetches that entry's status word. An entry found unowned parks the walker at that entry. The walker does not look at any later entry, and only a poll request makes it read the same status word again.

The two walkers and the initialization reader share one memory port. The port has a valid/ready request side and a separate read-response strobe, and only one transaction is in flight at a time.

Top module: `ring_own_mgr`

## Requirements
- R1: In and right after reset, `init_done`, `mem_req_valid`, `rx_owned`, `tx_owned`, `rx_parked` and `tx_parked` are all low, and no memory request is issued until `init_start` is pulsed.
- R2: After `init_start`, the block reads twelve 16-bit words, and only reads, at byte addresses P, P+2, ... P+22, where P = {`init_ptr_hi`, `init_ptr_lo`}. The reads go out in ascending order. `init_done` rises after the last one returns.
- R3: Initialization words 8 and 9 define the receive ring and words 10 and 11 define the transmit ring. The even word gives base bits 15:0. In the odd word, bits 7:0 give base bits 23:16 and bits 15:13 give the size exponent E, so the ring has 2^E entries. Once the walkers have loaded, each current address equals its ring's base, and each next address equals base+8, or the base itself when the ring has one entry.
- R4: Each walker reads word 1 of its current entry at address current+2. If bit 15 of that word is 1, it asserts its `*_owned` output.
- R5: If that bit is 0, the walker asserts `*_parked` and makes no memory request until its `*_poll` input is pulsed. A poll makes it read the same address again.
- R6: A `*_done` pulse while owned causes exactly one write to current+2, with the previously read word and bit 15 cleared. After that write, the current address takes the old next address and the next address steps by 8, wrapping to the base after the last entry. The walker then reads the new entry's word 1.
- R7: `*_done` while parked and `*_poll` while owned are ignored. They cause no memory transaction and no change of address or state.
- R8: While `mem_req_valid` is high and `mem_req_ready` is low, the request fields stay unchanged. No new request is presented while a read response is still due.
- R9: The rings run independently through the shared port. When both walkers have requests waiting, grants alternate between them.
- R10: `init_start` is ignored once initialization has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_start | input | 1 | Starts the initialization-block fetch |
| init_ptr_lo | input | 16 | Initialization block address bits 15:0 |
| init_ptr_hi | input | 8 | Initialization block address bits 23:16 |
| init_done | output | 1 | Initialization complete |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 24 | Byte address of the 16-bit word |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 16 | Read data |
| rx_poll | input | 1 | Re-read the parked receive entry |
| rx_done | input | 1 | Hand back the owned receive entry |
| rx_owned | output | 1 | Current receive entry is owned |
| rx_parked | output | 1 | Receive walker waits at an unowned entry |
| rx_cur_addr | output | 24 | Current receive descriptor address |
| rx_next_addr | output | 24 | Next receive descriptor address |
| tx_poll | input | 1 | Re-read the parked transmit entry |
| tx_done | input | 1 | Hand back the owned transmit entry |
| tx_owned | output | 1 | Current transmit entry is owned |
| tx_parked | output | 1 | Transmit walker waits at an unowned entry |
| tx_cur_addr | output | 24 | Current transmit descriptor address |
| tx_next_addr | output | 24 | Next transmit descriptor address |

## Verification
The assertions assume that the memory returns exactly one `mem_rsp_valid` strobe for each accepted read and none otherwise. They also assume that the ring fields of the initialization block describe a ring whose base is 8-byte aligned. The bench memory model answers each accepted read once, after a random delay of one to three cycles, and withholds `mem_req_ready` at random. The initialization block it serves holds aligned bases, and the random phase changes only the ownership bit and payload of status words. It never changes ring geometry after start-up.

// File: rtl/ring_own_pkg.sv
package ring_own_pkg;
    parameter int ADDR_W     = 24;
    parameter int DATA_W     = 16;
    parameter int LEN_W      = 3;
    parameter int OWN_BIT    = 15;
    parameter int LEN_LSB    = 13;
    parameter int DESC_BYTES = 8;
    parameter int WORD_BYTES = 2;
    parameter int STAT_WORD  = 1;
    parameter int INIT_WORDS = 12;
    parameter int IW_RX_LO   = 8;
    parameter int IW_RX_HI   = 9;
    parameter int IW_TX_LO   = 10;
    parameter int IW_TX_HI   = 11;
    parameter int NRING      = 2;
    localparam int HI_W      = ADDR_W - DATA_W;
    localparam int IDX_W     = $clog2(INIT_WORDS);
    localparam int NREQ      = NRING + 1;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  valid;
        logic  write;
        addr_t addr;
        data_t wdata;
    } mreq_t;

    typedef struct packed {
        addr_t            base;
        logic [LEN_W-1:0] lexp;
    } ring_cfg_t;

    typedef enum logic [2:0] {
        W_IDLE, W_FETCH, W_WAIT, W_OWNED, W_PARKED, W_WBACK
    } walk_st_t;

    typedef enum logic [1:0] {INI_IDLE, INI_REQ, INI_WAIT, INI_DONE} init_st_t;
    typedef enum logic [1:0] {ARB_IDLE, ARB_ISSUE, ARB_WAIT} arb_st_t;

    function automatic addr_t ring_span(input logic [LEN_W-1:0] lexp);
        return addr_t'(DESC_BYTES) << lexp;
    endfunction

    function automatic addr_t next_desc(input addr_t cur, input ring_cfg_t cfg);
        addr_t step;
        step = cur + addr_t'(DESC_BYTES);
        return (step == cfg.base + ring_span(cfg.lexp)) ? cfg.base : step;
    endfunction

    function automatic addr_t stat_addr(input addr_t cur);
        return cur + addr_t'(STAT_WORD * WORD_BYTES);
    endfunction
endpackage

// File: rtl/ring_init_seq.sv
module ring_init_seq
    import ring_own_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  addr_t     ptr,
    output mreq_t     req,
    input  logic      ack,
    input  logic      rsp_valid,
    input  data_t     rsp_data,
    output ring_cfg_t cfg_o [NRING],
    output logic      done
);
    init_st_t         st;
    logic [IDX_W-1:0] idx;
    addr_t            blk_base;
    ring_cfg_t        cfg_q [NRING];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= INI_IDLE;
            idx      <= '0;
            blk_base <= '0;
            for (int r = 0; r < NRING; r++) cfg_q[r] <= '0;
        end else begin
            case (st)
                INI_IDLE: if (start) begin
                    blk_base <= ptr;
                    idx      <= '0;
                    st       <= INI_REQ;
                end
                INI_REQ: if (ack) st <= INI_WAIT;
                INI_WAIT: if (rsp_valid) begin
                    case (int'(idx))
                        IW_RX_LO: cfg_q[0].base[DATA_W-1:0] <= rsp_data;
                        IW_RX_HI: begin
                            cfg_q[0].base[ADDR_W-1:DATA_W] <= rsp_data[HI_W-1:0];
                            cfg_q[0].lexp <= rsp_data[LEN_LSB +: LEN_W];
                        end
                        IW_TX_LO: cfg_q[1].base[DATA_W-1:0] <= rsp_data;
                        IW_TX_HI: begin
                            cfg_q[1].base[ADDR_W-1:DATA_W] <= rsp_data[HI_W-1:0];
                            cfg_q[1].lexp <= rsp_data[LEN_LSB +: LEN_W];
                        end
                        default: ;
                    endcase
                    if (int'(idx) == INIT_WORDS - 1) begin
                        st <= INI_DONE;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= INI_REQ;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req.valid = (st == INI_REQ);
        req.write = 1'b0;
        req.addr  = blk_base + addr_t'(idx) * addr_t'(WORD_BYTES);
        req.wdata = '0;
        done      = (st == INI_DONE);
        for (int r = 0; r < NRING; r++) cfg_o[r] = cfg_q[r];
    end

    AST_INIT_ADDR_ASCENDS: assert property (@(posedge clk) disable iff (rst)
        $rose(req.valid) && $past(st == INI_WAIT) |-> req.addr == $past(req.addr) + addr_t'(WORD_BYTES)) // R2
        else $error("init address did not step by one word");
endmodule

// File: rtl/ring_walker.sv
module ring_walker
    import ring_own_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  ring_cfg_t cfg,
    input  logic      poll,
    input  logic      hand_back,
    output logic      owned,
    output logic      parked,
    output addr_t     cur,
    output addr_t     nxt,
    output mreq_t     req,
    input  logic      ack,
    input  logic      rsp_valid,
    input  data_t     rsp_data
);
    walk_st_t st;
    data_t    stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= W_IDLE;
            cur    <= '0;
            nxt    <= '0;
            stat_q <= '0;
        end else begin
            case (st)
                W_IDLE: if (go) begin
                    cur <= cfg.base;
                    nxt <= next_desc(cfg.base, cfg);
                    st  <= W_FETCH;
                end
                W_FETCH: if (ack) st <= W_WAIT;
                W_WAIT: if (rsp_valid) begin
                    stat_q <= rsp_data;
                    st     <= rsp_data[OWN_BIT] ? W_OWNED : W_PARKED;
                end
                W_OWNED:  if (hand_back) st <= W_WBACK;
                W_PARKED: if (poll)      st <= W_FETCH;
                W_WBACK: if (ack) begin
                    cur <= nxt;
                    nxt <= next_desc(nxt, cfg);
                    st  <= W_FETCH;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        owned     = (st == W_OWNED);
        parked    = (st == W_PARKED);
        req.valid = (st == W_FETCH) || (st == W_WBACK);
        req.write = (st == W_WBACK);
        req.addr  = stat_addr(cur);
        req.wdata = stat_q & ~(data_t'(1) << OWN_BIT);
    end

    AST_OWN_FROM_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(owned) |-> $past(rsp_valid && rsp_data[OWN_BIT])) // R4
        else $error("owned without a set ownership bit");
    AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(req.valid && req.write) |-> $past(owned && hand_back)) // R6
        else $error("write-back without a hand-back");
    AST_STEP_ON_WB: assert property (@(posedge clk) disable iff (rst)
        $past(st != W_IDLE) && (cur != $past(cur)) |-> $past(req.write && ack)) // R6
        else $error("current pointer moved without a write-back");
    AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (rst)
        (st != W_IDLE) |-> (cur - cfg.base) < ring_span(cfg.lexp)) // R6
        else $error("current pointer outside its ring");
    AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        parked && !poll |=> parked && $stable(cur)) // R5
        else $error("parked walker moved without a poll");
endmodule

// File: rtl/ring_mem_arb.sv
module ring_mem_arb
    import ring_own_pkg::*;
#(
    parameter int N = NREQ
) (
    input  logic  clk,
    input  logic  rst,
    input  mreq_t req_i [N],
    output logic  ack_o [N],
    output logic  rsp_o [N],
    output logic  mem_req_valid,
    input  logic  mem_req_ready,
    output logic  mem_req_write,
    output addr_t mem_req_addr,
    output data_t mem_req_wdata,
    input  logic  mem_rsp_valid
);
    localparam int SEL_W = $clog2(N);

    arb_st_t          st;
    logic [SEL_W-1:0] sel_q, last_q, pick;
    logic             found;
    mreq_t            cur;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_q) + k) % N;
            if (!found && req_i[c].valid) begin
                found = 1'b1;
                pick  = SEL_W'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ARB_IDLE;
            sel_q  <= '0;
            last_q <= '0;
        end else begin
            case (st)
                ARB_IDLE: if (found) begin
                    sel_q <= pick;
                    st    <= ARB_ISSUE;
                end
                ARB_ISSUE: if (mem_req_ready) begin
                    last_q <= sel_q;
                    st     <= cur.write ? ARB_IDLE : ARB_WAIT;
                end
                ARB_WAIT: if (mem_rsp_valid) st <= ARB_IDLE;
                default: st <= ARB_IDLE;
            endcase
        end
    end

    always_comb begin
        cur           = req_i[sel_q];
        mem_req_valid = (st == ARB_ISSUE) && cur.valid;
        mem_req_write = cur.write;
        mem_req_addr  = cur.addr;
        mem_req_wdata = cur.wdata;
        for (int i = 0; i < N; i++) begin
            ack_o[i] = (st == ARB_ISSUE) && mem_req_ready && (int'(sel_q) == i);
            rsp_o[i] = (st == ARB_WAIT) && mem_rsp_valid && (int'(sel_q) == i);
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)) // R8
        else $error("request changed while stalled");
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rsp_valid |-> $onehot0({rsp_o[0], rsp_o[N-1]}) && !mem_req_valid) // R8
        else $error("response overlapped a request");
endmodule

// File: rtl/ring_own_mgr.sv
module ring_own_mgr
    import ring_own_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              init_start,
    input  logic [DATA_W-1:0] init_ptr_lo,
    input  logic [HI_W-1:0]   init_ptr_hi,
    output logic              init_done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              rx_poll,
    input  logic              rx_done,
    output logic              rx_owned,
    output logic              rx_parked,
    output logic [ADDR_W-1:0] rx_cur_addr,
    output logic [ADDR_W-1:0] rx_next_addr,
    input  logic              tx_poll,
    input  logic              tx_done,
    output logic              tx_owned,
    output logic              tx_parked,
    output logic [ADDR_W-1:0] tx_cur_addr,
    output logic [ADDR_W-1:0] tx_next_addr
);
    mreq_t     reqs  [NREQ];
    logic      acks  [NREQ];
    logic      rsps  [NREQ];
    ring_cfg_t cfgs  [NRING];
    logic      polls [NRING];
    logic      dones [NRING];
    logic      owns  [NRING];
    logic      parks [NRING];
    addr_t     curs  [NRING];
    addr_t     nxts  [NRING];

    ring_init_seq u_init (
        .clk       (clk),
        .rst       (rst),
        .start     (init_start),
        .ptr       ({init_ptr_hi, init_ptr_lo}),
        .req       (reqs[0]),
        .ack       (acks[0]),
        .rsp_valid (rsps[0]),
        .rsp_data  (mem_rsp_data),
        .cfg_o     (cfgs),
        .done      (init_done)
    );

    assign polls[0] = rx_poll;
    assign polls[1] = tx_poll;
    assign dones[0] = rx_done;
    assign dones[1] = tx_done;

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        ring_walker u_walk (
            .clk       (clk),
            .rst       (rst),
            .go        (init_done),
            .cfg       (cfgs[g]),
            .poll      (polls[g]),
            .hand_back (dones[g]),
            .owned     (owns[g]),
            .parked    (parks[g]),
            .cur       (curs[g]),
            .nxt       (nxts[g]),
            .req       (reqs[g+1]),
            .ack       (acks[g+1]),
            .rsp_valid (rsps[g+1]),
            .rsp_data  (mem_rsp_data)
        );
    end

    ring_mem_arb #(.N(NREQ)) u_arb (
        .clk           (clk),
        .rst           (rst),
        .req_i         (reqs),
        .ack_o         (acks),
        .rsp_o         (rsps),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid)
    );

    assign rx_owned     = owns[0];
    assign rx_parked    = parks[0];
    assign rx_cur_addr  = curs[0];
    assign rx_next_addr = nxts[0];
    assign tx_owned     = owns[1];
    assign tx_parked    = parks[1];
    assign tx_cur_addr  = curs[1];
    assign tx_next_addr = nxts[1];

    AST_IDLE_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !rx_owned && !tx_owned && !rx_parked && !tx_parked) // R1
        else $error("walker active before initialization");
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(init_done) |-> init_done) // R10
        else $error("init_done dropped");
endmodule

// File: tb/tb_ring_own_mgr.sv
`timescale 1ns/1ps
module tb_ring_own_mgr;
    import ring_own_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, init_start, init_done;
    logic [15:0] init_ptr_lo;
    logic [7:0]  init_ptr_hi;
    logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
    logic [23:0] mem_req_addr;
    logic [15:0] mem_req_wdata, mem_rsp_data;
    logic        rx_poll, rx_done, rx_owned, rx_parked;
    logic        tx_poll, tx_done, tx_owned, tx_parked;
    logic [23:0] rx_cur_addr, rx_next_addr, tx_cur_addr, tx_next_addr;

    ring_own_mgr dut (.*);

    int nchk = 0;
    int nerr = 0;

    typedef struct {
        bit          wr;
        int unsigned addr;
        int unsigned data;
    } txn_t;
    txn_t        tlog[$];
    bit [15:0]   mem [int unsigned];
    int unsigned ebase [2];
    int unsigned en    [2];
    int unsigned ecur  [2];

    function automatic bit [15:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 16'h0;
    endfunction

    function automatic int unsigned enext(input int r, input int unsigned a);
        return (a + 8 == ebase[r] + 8 * en[r]) ? ebase[r] : a + 8;
    endfunction

    function automatic int ring_of(input int unsigned a);
        return (a >= 32'h063000) ? 1 : 0;
    endfunction

    function automatic logic own_of(input int r);  return r ? tx_owned  : rx_owned;  endfunction
    function automatic logic park_of(input int r); return r ? tx_parked : rx_parked; endfunction
    function automatic logic [23:0] cur_of(input int r); return r ? tx_cur_addr  : rx_cur_addr;  endfunction
    function automatic logic [23:0] nxt_of(input int r); return r ? tx_next_addr : rx_next_addr; endfunction

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // memory model: random ready, read latency 1..3 cycles
    initial begin
        bit          p_valid, p_ready, p_write, rd_pend;
        int unsigned p_addr, p_wdata, rd_addr;
        int          rsp_cnt;
        p_valid = 0; p_ready = 0; p_write = 0; rd_pend = 0;
        p_addr = 0; p_wdata = 0; rd_addr = 0; rsp_cnt = 0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 16'h0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (rd_pend && mem_req_valid) begin
                nchk++; nerr++;
                $display("FAIL R8 request during pending read: actual %0h expected 0", mem_req_addr);
            end
            if (p_valid && p_ready) begin
                tlog.push_back('{wr: p_write, addr: p_addr, data: p_wdata});
                if (p_write) mem[p_addr] = p_wdata[15:0];
                else begin
                    rd_pend = 1; rd_addr = p_addr; rsp_cnt = 1 + int'($urandom % 3);
                end
            end else if (p_valid && !p_ready) begin
                chk("R8", "held request", {mem_req_valid, mem_req_write, mem_req_addr[22:0], 7'b0},
                    {1'b1, p_write, p_addr[22:0], 7'b0});
                chk("R8", "held wdata", {16'h0, mem_req_wdata}, p_wdata);
            end
            if (rd_pend) begin
                rsp_cnt--;
                if (rsp_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(rd_addr);
                    rd_pend = 0;
                end
            end
            mem_req_ready = !rd_pend && ($urandom % 4 != 0);
            p_valid = mem_req_valid;
            p_ready = mem_req_ready;
            p_write = mem_req_write;
            p_addr  = mem_req_addr;
            p_wdata = mem_req_wdata;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual 150000 cycles expected fewer");
        summary();
        $finish;
    end

    task automatic settle(input int r, input string rq);
        int k = 0;
        while (!(own_of(r) || park_of(r)) && k < 300) begin
            @(negedge clk);
            k++;
        end
        if (k >= 300) begin
            nchk++; nerr++;
            $display("FAIL %s ring %0d never settled: actual %0d expected <300", rq, r, k);
        end
    endtask

    task automatic pulse(input int r, input bit is_done);
        if (is_done) begin if (r) tx_done = 1; else rx_done = 1; end
        else begin if (r) tx_poll = 1; else rx_poll = 1; end
        @(negedge clk);
        rx_done = 0; tx_done = 0; rx_poll = 0; tx_poll = 0;
    endtask

    task automatic check_state(input int r, input string rq);
        bit [15:0] w;
        w = rd(ecur[r] + 2);
        chk(rq, "current address", cur_of(r), ecur[r]);
        chk(rq, "next address", nxt_of(r), enext(r, ecur[r]));
        chk(rq, "owned", own_of(r), w[15]);
        chk(rq, "parked", park_of(r), !w[15]);
    endtask

    task automatic do_done(input int r, input string rq);
        int unsigned a;
        bit [15:0]   w;
        a = ecur[r] + 2;
        w = rd(a) & 16'h7FFF;
        tlog.delete();
        pulse(r, 1);
        @(negedge clk);
        settle(r, rq);
        ecur[r] = enext(r, ecur[r]);
        chk(rq, "hand-back transactions", tlog.size(), 2);
        if (tlog.size() == 2) begin
            chk(rq, "write-back kind", tlog[0].wr, 1);
            chk(rq, "write-back address", tlog[0].addr, a);
            chk(rq, "write-back data", tlog[0].data, w);
            chk(rq, "next fetch address", {tlog[1].wr, tlog[1].addr[30:0]}, ecur[r] + 2);
        end
        check_state(r, rq);
    endtask

    task automatic do_poll(input int r, input string rq);
        tlog.delete();
        pulse(r, 0);
        @(negedge clk);
        settle(r, rq);
        chk(rq, "poll transactions", tlog.size(), 1);
        if (tlog.size() == 1)
            chk(rq, "poll re-read address", {tlog[0].wr, tlog[0].addr[30:0]}, ecur[r] + 2);
        check_state(r, rq);
    endtask

    task automatic quiet(input string rq, input int n);
        tlog.delete();
        repeat (n) @(negedge clk);
        chk(rq, "transactions while quiet", tlog.size(), 0);
    endtask

    initial begin
        void'($urandom(7));
        rst = 1; init_start = 0; init_ptr_lo = 16'h2340; init_ptr_hi = 8'h01;
        rx_poll = 0; rx_done = 0; tx_poll = 0; tx_done = 0;
        // initialization block at 0x012340
        mem[32'h012340] = 16'h0000;
        for (int i = 1; i < 8; i++) mem[32'h012340 + 2 * i] = 16'($urandom);
        mem[32'h012350] = 16'h2000;
        mem[32'h012352] = 16'h4005;   // E=2 -> 4 entries, high byte 05
        mem[32'h012354] = 16'h3000;
        mem[32'h012356] = 16'h2006;   // E=1 -> 2 entries, high byte 06
        mem[32'h052002] = 16'h8123;
        mem[32'h05200A] = 16'h80A5;
        mem[32'h052012] = 16'h0042;
        mem[32'h05201A] = 16'h8777;
        mem[32'h063002] = 16'h8F00;
        mem[32'h06300A] = 16'h0011;
        ebase[0] = 32'h052000; en[0] = 4; ecur[0] = ebase[0];
        ebase[1] = 32'h063000; en[1] = 2; ecur[1] = ebase[1];

        repeat (5) @(negedge clk);
        chk("R1", "init_done in reset", init_done, 0);
        chk("R1", "request in reset", mem_req_valid, 0);
        rst = 0;
        @(negedge clk);
        chk("R1", "owned/parked after reset", {rx_owned, tx_owned, rx_parked, tx_parked}, 0);
        quiet("R1", 10);

        // R2 / R3: initialization fetch
        tlog.delete();
        init_start = 1;
        @(negedge clk);
        init_start = 0;
        begin
            int k = 0;
            while (!init_done && k < 500) begin @(negedge clk); k++; end
            chk("R2", "init_done reached", init_done, 1);
        end
        settle(0, "R3");
        settle(1, "R3");
        chk("R2", "logged transactions", tlog.size() >= 12, 1);
        for (int i = 0; i < 12 && i < tlog.size(); i++)
            chk("R2", $sformatf("init word %0d", i), {tlog[i].wr, tlog[i].addr[30:0]}, 32'h012340 + 2 * i);
        check_state(0, "R3");
        check_state(1, "R3");
        // R4: first status reads
        chk("R4", "status reads after init", tlog.size(), 14);
        if (tlog.size() == 14)
            chk("R4", "status read addresses", tlog[12].addr + tlog[13].addr, 32'h052002 + 32'h063002);

        // R7: poll while owned
        pulse(0, 0);
        quiet("R7", 8);
        chk("R7", "still owned after poll", rx_owned, 1);

        // R6 / R5 receive walk
        do_done(0, "R6");
        do_done(0, "R5");
        quiet("R5", 10);
        chk("R5", "parked address unchanged", rx_cur_addr, 24'h052010);
        pulse(0, 1);
        quiet("R7", 8);
        chk("R7", "parked after done", rx_parked, 1);
        mem[32'h052012] = 16'h8042;
        do_poll(0, "R5");
        do_done(0, "R6");
        do_done(0, "R6");     // wraps to the base, entry 0 handed back earlier
        chk("R6", "wrap to base", rx_cur_addr, 24'h052000);

        // transmit walk: next wraps
        do_done(1, "R6");
        chk("R6", "tx next wraps", tx_next_addr, 24'h063000);

        // R9: both rings at once
        mem[32'h052002] = mem[32'h052002] | 16'h8000;
        mem[32'h06300A] = mem[32'h06300A] | 16'h8000;
        tlog.delete();
        rx_poll = 1; tx_poll = 1;
        @(negedge clk);
        rx_poll = 0; tx_poll = 0;
        @(negedge clk);
        settle(0, "R9"); settle(1, "R9");
        chk("R9", "joint poll transactions", tlog.size(), 2);
        if (tlog.size() == 2) chk("R9", "one read per ring", ring_of(tlog[0].addr) + ring_of(tlog[1].addr), 1);
        check_state(0, "R9"); check_state(1, "R9");
        mem[32'h05200A] = 16'h80A5;
        mem[32'h063002] = 16'h8F00;
        tlog.delete();
        rx_done = 1; tx_done = 1;
        @(negedge clk);
        rx_done = 0; tx_done = 0;
        @(negedge clk);
        settle(0, "R9"); settle(1, "R9");
        ecur[0] = enext(0, ecur[0]);
        ecur[1] = enext(1, ecur[1]);
        chk("R9", "joint hand-back transactions", tlog.size(), 4);
        if (tlog.size() == 4)
            for (int i = 0; i < 3; i++)
                chk("R9", $sformatf("alternation %0d", i), ring_of(tlog[i].addr) != ring_of(tlog[i+1].addr), 1);
        check_state(0, "R9"); check_state(1, "R9");

        // R10: restart ignored
        init_ptr_lo = 16'h0000;
        pulse(0, 0);  // rx is owned, poll ignored as well
        init_start = 1;
        @(negedge clk);
        init_start = 0;
        quiet("R10", 12);
        check_state(0, "R10"); check_state(1, "R10");

        // constrained random walk
        for (int it = 0; it < 120; it++) begin
            int r;
            int c;
            r = int'($urandom % 2);
            c = int'($urandom % 4);
            if (own_of(r)) begin
                if (c == 0) begin
                    pulse(r, 0);
                    quiet("R7", 6);
                    check_state(r, "R7");
                end else begin
                    mem[enext(r, ecur[r]) + 2] = 16'($urandom);
                    do_done(r, "R6");
                end
            end else begin
                if (c == 0) begin
                    pulse(r, 1);
                    quiet("R7", 6);
                    check_state(r, "R7");
                end else begin
                    mem[ecur[r] + 2] = 16'($urandom);
                    do_poll(r, "R5");
                end
            end
        end

        summary();
        $finish;
    end
endmodule